// File: doc/BRIEF.md
# Bootstrap SRAM copy engine

The block keeps a small bootstrap program in a local SRAM that is never reset, so the image survives while the rest of the device is held in reset or powered down. On command it copies a window of that SRAM, one 32-bit dword per clock, into the instruction SRAM of an embedded processor. The processor is held in reset while the copy runs.

Software reaches everything through a word-addressed host port. The lower half of the address space holds eight control words: source offset, destination address, dword count, control, and four pass-through words (code pointer, data pointer, code length, data length). The bootstrap program reads these four later; the block only stores them. The upper half is a window onto the bootstrap SRAM. A copy starts when the host sets the go bit. It also starts when a power-management wake pulse arrives while the arm bit is set, so the retained image is loaded again on every power-up without host action.

Top module: `boot_copy_engine`

## Requirements
- R1: Host word address DEPTH+k (0x40+k at the default DEPTH of 64) reaches bootstrap SRAM word k. A write lands on the clock edge where host_we_i is high. A read returns the word on host_rdata_o in the cycle after host_re_i.
- R2: The bootstrap SRAM contents are kept across an assertion of rst_ni.
- R3: Control words live at host addresses 0 to 7: source offset (0, low log2(DEPTH) bits), destination (1), dword count (2, 16 bits), control (3), code pointer (4), data pointer (5), code length (6), data length (7). Each reset to 0 and reads back what was last written.
- R4: Writing control bit 0 (go) as 1 starts a copy. In the i-th busy cycle, imem_we_o is high, imem_addr_o holds destination+i, and imem_wdata_o holds bootstrap word source+i.
- R5: busy_o, core_rst_o and control bit 0 on readback are 1 from the cycle after the start until the last dword is written. done_o is a single-cycle pulse in the first cycle after busy_o falls.
- R6: The number of dwords copied is min(count, DEPTH - source). The source address never wraps.
- R7: A copy with an effective length of zero keeps busy_o high for exactly one cycle, makes no write, and then pulses done_o.
- R8: Control bit 1 (arm) is stored and read back. While it is set, every wake_i pulse starts the same copy with the current registers.
- R9: A wake_i pulse is ignored while arm is clear, and also while a copy is busy.
- R10: While busy, host writes to the SRAM window are dropped and host reads of the window return 0.
- R11: Setting go while a copy is busy neither restarts nor lengthens the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_addr_i | input | log2(DEPTH)+1 | Host word address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, one cycle after host_re_i |
| wake_i | input | 1 | Power-management wake pulse |
| imem_we_o | output | 1 | Instruction SRAM write enable |
| imem_addr_o | output | IMEM_AW | Instruction SRAM dword address |
| imem_wdata_o | output | 32 | Instruction SRAM write data |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle copy completion pulse |
| core_rst_o | output | 1 | Processor reset hold, high during a copy |

## Verification
The bench runs copies whose source and length push against the end of the SRAM. If the clamp is wrong, the copy writes extra dwords, or the source wraps and repeats the first words of the image. A zero-length copy must make no write and hold busy for exactly one cycle; an off-by-one engine either writes one dword or hangs for 65536 cycles. Wake pulses are sent with arm clear and in the middle of a running copy, and go is rewritten mid-copy; a design that restarts shows extra writes or a longer busy window. Host SRAM writes made during a copy must not change the retained image, and reads made then must return zero. A reset must not clear the image.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
  typedef enum logic [2:0] {
    SEL_SRC  = 3'd0,
    SEL_DST  = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_IPTR = 3'd4,
    SEL_DPTR = 3'd5,
    SEL_ILEN = 3'd6,
    SEL_DLEN = 3'd7
  } reg_sel_e;

  localparam int unsigned CTRL_GO  = 0;
  localparam int unsigned CTRL_ARM = 1;
endpackage

// File: rtl/boot_sram.sv
module boot_sram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output logic [DW-1:0]    rdata_a_o,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [DW-1:0]    rdata_b_o
);
  // retained array: deliberately no reset
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/boot_regs.sv
module boot_regs
  import boot_copy_pkg::*;
#(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned DW      = 32,
  parameter int unsigned IMEM_AW = 16,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned HA_W  = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic               host_re_i,
  input  logic [HA_W-1:0]    host_addr_i,
  input  logic [DW-1:0]      host_wdata_i,
  output logic [DW-1:0]      host_rdata_o,
  input  logic               busy_i,
  input  logic [DW-1:0]      sram_rdata_i,
  output logic               sram_we_o,
  output logic [IDX_W-1:0]   sram_idx_o,
  output logic [IDX_W-1:0]   src_o,
  output logic [IMEM_AW-1:0] dst_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               go_o,
  output logic               arm_o
);
  logic           in_win, reg_hit;
  reg_sel_e       sel;
  logic [DW-1:0]  iptr_q, dptr_q, ilen_q, dlen_q, rdata_q, rd_mux;
  logic [IDX_W-1:0]   src_q;
  logic [IMEM_AW-1:0] dst_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               arm_q;

  assign in_win     = host_addr_i[HA_W-1];
  assign reg_hit    = !in_win && (host_addr_i[HA_W-2:3] == '0);
  assign sel        = reg_sel_e'(host_addr_i[2:0]);
  assign sram_idx_o = host_addr_i[IDX_W-1:0];
  // engine owns the SRAM while busy
  assign sram_we_o  = host_we_i && in_win && !busy_i;
  assign go_o       = host_we_i && reg_hit && (sel == SEL_CTRL) && host_wdata_i[CTRL_GO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      arm_q  <= 1'b0;
      iptr_q <= '0;
      dptr_q <= '0;
      ilen_q <= '0;
      dlen_q <= '0;
    end else if (host_we_i && reg_hit) begin
      case (sel)
        SEL_SRC:  src_q  <= host_wdata_i[IDX_W-1:0];
        SEL_DST:  dst_q  <= host_wdata_i[IMEM_AW-1:0];
        SEL_CNT:  cnt_q  <= host_wdata_i[CNT_W-1:0];
        SEL_CTRL: arm_q  <= host_wdata_i[CTRL_ARM];
        SEL_IPTR: iptr_q <= host_wdata_i;
        SEL_DPTR: dptr_q <= host_wdata_i;
        SEL_ILEN: ilen_q <= host_wdata_i;
        SEL_DLEN: dlen_q <= host_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      rd_mux = busy_i ? '0 : sram_rdata_i;
    end else if (reg_hit) begin
      case (sel)
        SEL_SRC:  rd_mux = DW'(src_q);
        SEL_DST:  rd_mux = DW'(dst_q);
        SEL_CNT:  rd_mux = DW'(cnt_q);
        SEL_CTRL: rd_mux = DW'({arm_q, busy_i});
        SEL_IPTR: rd_mux = iptr_q;
        SEL_DPTR: rd_mux = dptr_q;
        SEL_ILEN: rd_mux = ilen_q;
        SEL_DLEN: rd_mux = dlen_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (host_re_i) rdata_q <= rd_mux;
  end

  assign host_rdata_o = rdata_q;
  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;
  assign arm_o = arm_q;

  p_win_read_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && in_win && busy_i) |=> (host_rdata_o == '0));
  p_ctrl_read_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && reg_hit && sel == SEL_CTRL) |=> (host_rdata_o[CTRL_GO] == $past(busy_i)));
endmodule

// File: rtl/boot_copy_fsm.sv
module boot_copy_fsm #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned DW      = 32,
  parameter int unsigned IMEM_AW = 16,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic               wake_i,
  input  logic               arm_i,
  input  logic [IDX_W-1:0]   src_i,
  input  logic [IMEM_AW-1:0] dst_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [DW-1:0]      sram_rdata_i,
  output logic [IDX_W-1:0]   sram_raddr_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               imem_we_o,
  output logic [IMEM_AW-1:0] imem_addr_o,
  output logic [DW-1:0]      imem_wdata_o
);
  logic               busy_q, done_q, start, last;
  logic [IDX_W:0]     src_q;
  logic [IMEM_AW-1:0] dst_q;
  logic [CNT_W-1:0]   rem_q, avail, eff_cnt;

  assign start   = !busy_q && (go_i || (wake_i && arm_i));
  // clamp so the source never runs past the last SRAM word
  assign avail   = CNT_W'(DEPTH) - CNT_W'(src_i);
  assign eff_cnt = (cnt_i > avail) ? avail : cnt_i;
  assign last    = (rem_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        src_q  <= {1'b0, src_i};
        dst_q  <= dst_i;
        rem_q  <= eff_cnt;
      end else if (busy_q) begin
        if (rem_q != '0) begin
          src_q <= src_q + (IDX_W+1)'(1);
          dst_q <= dst_q + IMEM_AW'(1);
          rem_q <= rem_q - CNT_W'(1);
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sram_raddr_o = src_q[IDX_W-1:0];
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign imem_we_o    = busy_q && (rem_q != '0);
  assign imem_addr_o  = dst_q;
  assign imem_wdata_o = sram_rdata_i;

  p_we_in_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_we_o |-> busy_o);
  p_src_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_we_o |-> (int'(src_q) < int'(DEPTH)));
  p_dst_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_we_o && $past(imem_we_o) && $past(busy_o)) |-> (imem_addr_o == $past(imem_addr_o) + IMEM_AW'(1)));
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o || $past(start)) && $past(busy_o));
  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !busy_o) |=> !done_o);
  p_no_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> busy_o && (rem_q == $past(rem_q) - CNT_W'(1)));
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned DW      = 32,
  parameter int unsigned IMEM_AW = 16,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned HA_W  = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic               host_re_i,
  input  logic [HA_W-1:0]    host_addr_i,
  input  logic [DW-1:0]      host_wdata_i,
  output logic [DW-1:0]      host_rdata_o,
  input  logic               wake_i,
  output logic               imem_we_o,
  output logic [IMEM_AW-1:0] imem_addr_o,
  output logic [DW-1:0]      imem_wdata_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               core_rst_o
);
  logic               busy, done, go, arm, sram_we;
  logic [IDX_W-1:0]   host_idx, copy_idx, src;
  logic [IMEM_AW-1:0] dst;
  logic [CNT_W-1:0]   cnt;
  logic [DW-1:0]      host_sram_rd, copy_sram_rd;

  boot_sram #(.DEPTH(DEPTH), .DW(DW)) u_sram (
    .clk_i     (clk_i),
    .we_i      (sram_we),
    .waddr_i   (host_idx),
    .wdata_i   (host_wdata_i),
    .raddr_a_i (host_idx),
    .rdata_a_o (host_sram_rd),
    .raddr_b_i (copy_idx),
    .rdata_b_o (copy_sram_rd)
  );

  boot_regs #(.DEPTH(DEPTH), .DW(DW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_re_i    (host_re_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .busy_i       (busy),
    .sram_rdata_i (host_sram_rd),
    .sram_we_o    (sram_we),
    .sram_idx_o   (host_idx),
    .src_o        (src),
    .dst_o        (dst),
    .cnt_o        (cnt),
    .go_o         (go),
    .arm_o        (arm)
  );

  boot_copy_fsm #(.DEPTH(DEPTH), .DW(DW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go),
    .wake_i       (wake_i),
    .arm_i        (arm),
    .src_i        (src),
    .dst_i        (dst),
    .cnt_i        (cnt),
    .sram_rdata_i (copy_sram_rd),
    .sram_raddr_o (copy_idx),
    .busy_o       (busy),
    .done_o       (done),
    .imem_we_o    (imem_we_o),
    .imem_addr_o  (imem_addr_o),
    .imem_wdata_o (imem_wdata_o)
  );

  assign busy_o     = busy;
  assign done_o     = done;
  assign core_rst_o = busy;

  p_wake_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !arm && !go && !busy) |=> !busy);
  p_start_on_go_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !busy) |=> busy_o && core_rst_o);
endmodule

// File: tb/boot_copy_engine_bench.sv
module boot_copy_engine_bench;
  localparam int DEPTH = 64;
  localparam int IAW   = 16;
  localparam int BASE  = DEPTH;

  logic        clk = 0, rst_n = 0;
  logic        we = 0, re = 0, wake = 0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        imem_we, busy, done, core_rst;
  logic [IAW-1:0] imem_addr;
  logic [31:0] imem_wdata;

  boot_copy_engine u_boot_copy_engine (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_re_i(re),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .wake_i(wake), .imem_we_o(imem_we), .imem_addr_o(imem_addr),
    .imem_wdata_o(imem_wdata), .busy_o(busy), .done_o(done), .core_rst_o(core_rst)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem_m [DEPTH];
  bit arm_m = 0;

  // negedge monitor
  int wr_n = 0, busy_cyc = 0, done_n = 0, done_bad = 0, rst_bad = 0;
  logic [IAW-1:0] log_a [4096];
  logic [31:0]    log_d [4096];
  logic prev_busy = 0, prev_done = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (imem_we && wr_n < 4096) begin
        log_a[wr_n] = imem_addr;
        log_d[wr_n] = imem_wdata;
        wr_n = wr_n + 1;
      end
      if (busy) busy_cyc = busy_cyc + 1;
      if (core_rst !== busy) rst_bad = rst_bad + 1;
      if (done) begin
        done_n = done_n + 1;
        if (busy || !prev_busy || prev_done) done_bad = done_bad + 1;
      end
    end
    prev_busy = busy;
    prev_done = done;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = 7'(a); wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic host_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    re = 1; addr = 7'(a);
    @(negedge clk);
    re = 0;
    d = rdata;
  endtask

  function automatic int eff_len(input int src, input int cnt);
    return (cnt > DEPTH - src) ? DEPTH - src : cnt;
  endfunction

  // poke: 0 none, 1 wake mid-copy, 2 go mid-copy, 3 host SRAM write+read mid-copy
  task automatic run_copy(input int src, input int dst, input int cnt,
                          input bit by_wake, input int poke, input string req);
    int w0, d0, exp_n, lim, bad;
    logic [31:0] r;
    host_wr(0, 32'(src));
    host_wr(1, 32'(dst));
    host_wr(2, 32'(cnt));
    w0 = wr_n; d0 = done_n;
    busy_cyc = 0;
    if (by_wake) begin
      @(negedge clk); wake = 1;
      @(negedge clk); wake = 0;
    end else begin
      host_wr(3, {30'b0, arm_m, 1'b1});
    end
    check(busy === 1'b1, req, "busy after start", busy, 1);
    if (poke == 1) begin
      repeat (2) @(negedge clk);
      wake = 1; @(negedge clk); wake = 0;
    end else if (poke == 2) begin
      repeat (2) @(negedge clk);
      host_wr(3, {30'b0, arm_m, 1'b1});
    end else if (poke == 3) begin
      host_wr(BASE + 5, ~mem_m[5]);
      host_rd(BASE + 7, r);
      check(r === 32'h0, "R10", "window read while busy", r, 0);
    end
    lim = 0;
    while (done_n == d0 && lim < 500) begin @(negedge clk); lim++; end
    check(lim < 500, req, "copy completed", lim, 0);
    exp_n = eff_len(src, cnt);
    check(wr_n - w0 == exp_n, req, "dword writes", wr_n - w0, exp_n);
    check(busy_cyc == ((exp_n == 0) ? 1 : exp_n), req, "busy cycles",
          busy_cyc, (exp_n == 0) ? 1 : exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < wr_n - w0; i++) begin
      if (bad < 0 && (log_a[w0+i] !== IAW'(dst + i) || log_d[w0+i] !== mem_m[src+i])) bad = i;
    end
    if (bad >= 0)
      check(0, "R4", "write contents", log_d[w0+bad], mem_m[src+bad]);
    else
      check(1, "R4", "write contents", 0, 0);
    @(negedge clk);
    check(done === 1'b0, "R5", "done single pulse", done, 0);
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] v;
    int s, c, w0;
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && imem_we === 0 && core_rst === 0, "R5",
          "idle outputs in reset", {busy, done, imem_we, core_rst}, 0);
    rst_n = 1;
    @(negedge clk);
    // R3 reset values
    for (int a = 0; a < 8; a++) begin
      host_rd(a, r);
      check(r === 32'h0, "R3", $sformatf("reg %0d reset", a), r, 0);
    end
    // R1 fill and verify SRAM
    for (int k = 0; k < DEPTH; k++) begin
      mem_m[k] = $urandom();
      host_wr(BASE + k, mem_m[k]);
    end
    for (int k = 0; k < DEPTH; k += 7) begin
      host_rd(BASE + k, r);
      check(r === mem_m[k], "R1", $sformatf("sram word %0d", k), r, mem_m[k]);
    end
    // R3 register readback
    host_wr(0, 32'd13); host_rd(0, r); check(r === 32'd13, "R3", "src", r, 13);
    host_wr(1, 32'h0001_2345); host_rd(1, r); check(r === 32'h2345, "R3", "dst width", r, 32'h2345);
    host_wr(2, 32'h0003_ABCD); host_rd(2, r); check(r === 32'hABCD, "R3", "count width", r, 32'hABCD);
    for (int a = 4; a < 8; a++) begin
      v = $urandom();
      host_wr(a, v); host_rd(a, r);
      check(r === v, "R3", $sformatf("pass-through %0d", a), r, v);
    end
    // R4 directed
    run_copy(0, 16'h100, 8, 0, 0, "R4");
    // R5 ctrl readback during busy
    host_wr(0, 0); host_wr(1, 0); host_wr(2, 30);
    host_wr(3, 1);
    host_rd(3, r);
    check(r[0] === 1'b1, "R5", "go reads 1 while busy", r[0], 1);
    repeat (40) @(negedge clk);
    host_rd(3, r);
    check(r[0] === 1'b0, "R5", "go self-clears", r[0], 0);
    // R6 clamp
    run_copy(50, 16'h200, 100, 0, 0, "R6");
    run_copy(0, 16'h300, DEPTH + 5, 0, 0, "R6");
    run_copy(63, 16'h400, 16'hFFFF, 0, 0, "R6");
    // R7 zero length
    run_copy(10, 16'h500, 0, 0, 0, "R7");
    // R10 host access during busy
    run_copy(0, 16'h600, 40, 0, 3, "R10");
    host_rd(BASE + 5, r);
    check(r === mem_m[5], "R10", "write during busy dropped", r, mem_m[5]);
    // R11 go mid-copy
    run_copy(4, 16'h700, 30, 0, 2, "R11");
    // R8 arm and wake
    arm_m = 1;
    host_wr(3, 32'h2);
    host_rd(3, r);
    check(r[1:0] === 2'b10, "R8", "arm readback", r[1:0], 2);
    run_copy(8, 16'h800, 12, 1, 0, "R8");
    run_copy(8, 16'h800, 12, 1, 0, "R8");
    // R9 wake during busy
    run_copy(0, 16'h900, 30, 1, 1, "R9");
    // R9 wake with arm clear
    arm_m = 0;
    host_wr(3, 32'h0);
    w0 = wr_n; busy_cyc = 0;
    @(negedge clk); wake = 1; @(negedge clk); wake = 0;
    repeat (5) @(negedge clk);
    check(wr_n == w0 && busy_cyc == 0, "R9", "wake while disarmed", wr_n - w0, 0);
    // random copies
    for (int t = 0; t < 16; t++) begin
      s = int'($urandom_range(0, DEPTH - 1));
      c = int'($urandom_range(0, DEPTH + 8));
      run_copy(s, int'($urandom_range(0, 16'h7000)), c, 0, 0, "R4");
    end
    // R2 retention across reset
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
    host_rd(BASE + 33, r);
    check(r === mem_m[33], "R2", "sram kept over reset", r, mem_m[33]);
    host_rd(3, r);
    check(r === 32'h0, "R3", "ctrl after reset", r, 0);
    check(done_bad == 0, "R5", "done pulse timing", done_bad, 0);
    check(rst_bad == 0, "R5", "core reset tracks busy", rst_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule